// File: doc/BRIEF.md
# Flanger Delay Line with Regeneration

This block is the per-sample datapath of a flanger or chorus effect. Each sample strobe brings one 10-bit unsigned audio sample, an 8-bit delay offset and a two-bit active-low regeneration mode. The sample, optionally averaged with the delayed sample played on the previous strobe, is written into a 256-entry circular buffer at the record index. A delayed sample is read back at the record index minus the offset. The block then emits the equal-weight average of the recorded and the played sample, which gives full-depth comb notches.

The zero level of the audio is mid-scale, 0x200. After reset the block spends 256 cycles filling every buffer entry with mid-scale and reports this with a busy output. Strobes are accepted only once busy is low. A modulation source outside the block sweeps the delay offset. The converters that feed it and the output modulator it drives are also outside the block.

Top module: `flanger_delay_line`

## Requirements
- R1: While reset is low, busy is 1, mix_valid is 0 and mix_out is 0x200. After reset is released, busy stays high for exactly 256 clock cycles, and every buffer entry then holds 0x200.
- R2: A strobe that arrives while busy is high is ignored. It raises no mix_valid, leaves mix_out unchanged and does not advance the record index.
- R3: Each accepted strobe writes the buffer at the record index and then advances the index by one, wrapping from 255 to 0. Idle cycles leave the index unchanged.
- R4: The play index is (record index − delay_off) mod 256. With delay_off = 0 the played sample is the sample recorded on that same strobe.
- R5: regen_mode_n = 2'b11 (bit 1 = A, bit 0 = B) selects no feedback, and the recorded sample is the raw input.
- R6: regen_mode_n = 2'b01 selects positive feedback. The recorded sample is bits 10:1 of the 11-bit sum of the input and the previous played sample.
- R7: regen_mode_n = 2'b10 selects negative feedback. The recorded sample is bits 10:1 of the 11-bit sum of the input and the bitwise complement of the previous played sample.
- R8: regen_mode_n = 2'b00 records as in R7. It also replaces the played sample with its bitwise complement in the output mix.
- R9: mix_out = bits 10:1 of the 11-bit sum of the recorded sample and the (possibly complemented) played sample. mix_valid is high for exactly the one cycle after an accepted strobe, and mix_out holds until the next accepted strobe.
- R10: The feedback value is the uncomplemented sample played on the previous accepted strobe. After reset it is 0x200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also restarts the buffer fill |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | 10 | Unsigned input sample, 0x200 = silence |
| delay_off | input | 8 | Delay in samples between record and play index |
| regen_mode_n | input | 2 | Active-low regeneration mode, bit 1 = A, bit 0 = B |
| busy | output | 1 | High while the buffer is being filled with mid-scale |
| mix_valid | output | 1 | One-cycle pulse after each accepted strobe |
| mix_out | output | 10 | Wet/dry average, held between strobes |

## Verification
The bench sweeps all four modes over more than a thousand strobes, so the record index wraps several times. Offsets of 0, 1 and 255 appear among the others, and the inputs include the rails. The zero-offset case catches a design without write-to-read bypass, which would return the entry written 256 strobes earlier. Rail inputs with high feedback catch a sum that drops its carry, and negative modes catch two's-complement negation used in place of the complement. Mode 2'b00 catches a wet inversion applied to the wrong mode. A second reset mid-run checks that both the buffer and the feedback register return to mid-scale.

// File: rtl/flg_pkg.sv
// Shared types for the flanger delay line.
// Assumes the mode pins are active low, with A on bit 1 and B on bit 0.
package flg_pkg;
    typedef enum logic [1:0] {
        RG_NEG_INV = 2'b00,  // negative feedback, inverted wet path
        RG_POS     = 2'b01,  // positive feedback
        RG_NEG     = 2'b10,  // negative feedback
        RG_NONE    = 2'b11   // no feedback
    } regen_mode_e;
endpackage

// File: rtl/flg_index_ctrl.sv
// Index control: runs the post-reset mid-scale fill and keeps the
// circular record index. It derives the play index from the delay offset.
// Assumes accept is never high while busy.
module flg_index_ctrl #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] delay_off,
    output logic              busy,
    output logic [ADDR_W-1:0] fill_idx,
    output logic [ADDR_W-1:0] wr_idx,
    output logic [ADDR_W-1:0] rd_idx
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    // Fill sequencer: one entry per cycle until the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_idx <= '0;
            busy     <= 1'b1;
        end else if (busy) begin
            fill_idx <= fill_idx + 1'b1;
            if (fill_idx == LAST) busy <= 1'b0;
        end
    end

    // Record index: advances once per accepted strobe, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_idx <= '0;
        else if (accept) wr_idx <= wr_idx + 1'b1;
    end

    // Play index trails the record index by the offset, modulo the depth.
    always_comb rd_idx = wr_idx - delay_off;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wr_idx == ADDR_W'($past(wr_idx) + 1'b1));
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(wr_idx));
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);
    p_busy_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
    p_fill_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> fill_idx == '0);
endmodule

// File: rtl/flg_sample_store.sv
// Circular sample buffer with one write port and one combinational read.
// A read that hits the address being written returns the new data.
// No reset: contents are set by the fill sequence.
module flg_sample_store #(
    parameter int SAMPLE_W = 10,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port with same-address bypass, so a zero delay returns the live sample.
    always_comb rdata = (we && (raddr == waddr)) ? wdata : mem[raddr];
endmodule

// File: rtl/flg_regen.sv
// Regeneration: forms the sample to record from the input and the previous
// played sample, according to the mode. Purely combinational.
module flg_regen
    import flg_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic [SAMPLE_W-1:0] din,
    input  logic [SAMPLE_W-1:0] fb,
    input  regen_mode_e         mode,
    output logic [SAMPLE_W-1:0] rec
);
    logic [SAMPLE_W-1:0] fb_pol;
    logic [SAMPLE_W:0]   sum;

    // Feedback polarity: negative modes use the one's complement.
    always_comb begin
        unique case (mode)
            RG_NEG, RG_NEG_INV: fb_pol = ~fb;
            default:            fb_pol = fb;
        endcase
    end

    // Average with carry kept, or bypass when feedback is off.
    always_comb begin
        sum = {1'b0, din} + {1'b0, fb_pol};
        rec = (mode == RG_NONE) ? din : SAMPLE_W'(sum >> 1);
    end
endmodule

// File: rtl/flg_mixer.sv
// Wet/dry mixer: equal-weight average of the recorded and played samples,
// with the wet path complemented in the inverted-mix mode. Combinational.
module flg_mixer
    import flg_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input  logic [SAMPLE_W-1:0] rec,
    input  logic [SAMPLE_W-1:0] played,
    input  regen_mode_e         mode,
    output logic [SAMPLE_W-1:0] mix
);
    logic [SAMPLE_W-1:0] wet;
    logic [SAMPLE_W:0]   sum;

    // Wet polarity and 50:50 sum with the carry retained.
    always_comb begin
        wet = (mode == RG_NEG_INV) ? ~played : played;
        sum = {1'b0, rec} + {1'b0, wet};
        mix = SAMPLE_W'(sum >> 1);
    end
endmodule

// File: rtl/flanger_delay_line.sv
// Flanger delay line top. Per accepted strobe, in one cycle: record a sample,
// read the delayed one, update the feedback and register the mix.
// Assumes the inputs are stable in the cycle the strobe is high.
module flanger_delay_line
    import flg_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_in,
    input  logic [ADDR_W-1:0]   delay_off,
    input  logic [1:0]          regen_mode_n,
    output logic                busy,
    output logic                mix_valid,
    output logic [SAMPLE_W-1:0] mix_out
);
    localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

    logic                accept;
    regen_mode_e         mode;
    logic [ADDR_W-1:0]   fill_idx, wr_idx, rd_idx, waddr;
    logic [SAMPLE_W-1:0] fb_q, rec, played, mix, wdata;
    logic                we;

    // Strobe qualification and mode decode for this sample.
    always_comb begin
        accept = smp_valid && !busy;
        mode   = regen_mode_e'(regen_mode_n);
    end

    flg_index_ctrl #(.ADDR_W(ADDR_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .accept(accept), .delay_off(delay_off),
        .busy(busy), .fill_idx(fill_idx), .wr_idx(wr_idx), .rd_idx(rd_idx)
    );

    flg_regen #(.SAMPLE_W(SAMPLE_W)) u_regen (
        .din(smp_in), .fb(fb_q), .mode(mode), .rec(rec)
    );

    // Write source: mid-scale during the fill, the recorded sample afterwards.
    always_comb begin
        we    = busy || accept;
        waddr = busy ? fill_idx : wr_idx;
        wdata = busy ? MID : rec;
    end

    flg_sample_store #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(rd_idx), .rdata(played)
    );

    flg_mixer #(.SAMPLE_W(SAMPLE_W)) u_mix (
        .rec(rec), .played(played), .mode(mode), .mix(mix)
    );

    // Output and feedback registers, updated only by accepted strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q      <= MID;
            mix_out   <= MID;
            mix_valid <= 1'b0;
        end else begin
            mix_valid <= accept;
            if (accept) begin
                fb_q    <= played;
                mix_out <= mix;
            end
        end
    end

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mix_valid);
    p_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !mix_valid);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(mix_out));
    p_fb_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> fb_q == $past(played));
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && delay_off == '0) |-> played == rec);
    p_dry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode == RG_NONE) |-> rec == smp_in);
endmodule

// File: tb/flanger_delay_line_tb.sv
// Self-checking bench: a behavioural buffer model computes every expected mix.
module flanger_delay_line_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       smp_valid;
    logic [9:0] smp_in;
    logic [7:0] delay_off;
    logic [1:0] regen_mode_n;
    logic       busy, mix_valid;
    logic [9:0] mix_out;

    int tests = 0;
    int fails = 0;

    logic [9:0] m_mem [256];
    logic [7:0] m_wr;
    logic [9:0] m_fb;
    logic [9:0] last_exp;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flanger_delay_line u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .delay_off(delay_off), .regen_mode_n(regen_mode_n),
        .busy(busy), .mix_valid(mix_valid), .mix_out(mix_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 256; i++) m_mem[i] = 10'h200;
        m_wr     = 8'd0;
        m_fb     = 10'h200;
        last_exp = 10'h200;
    endtask

    // Drive one strobe at a negedge, check the result one edge later.
    task automatic strobe(input logic [9:0] x, input logic [7:0] off,
                          input logic [1:0] m, input string tag);
        logic [10:0] s;
        logic [9:0]  rec, pl, wet, ex;
        smp_valid = 1'b1; smp_in = x; delay_off = off; regen_mode_n = m;
        case (m)
            2'b11:   rec = x;
            2'b01:   begin s = {1'b0, x} + {1'b0, m_fb};  rec = s[10:1]; end
            default: begin s = {1'b0, x} + {1'b0, ~m_fb}; rec = s[10:1]; end
        endcase
        pl  = (off == 8'd0) ? rec : m_mem[8'(m_wr - off)];
        wet = (m == 2'b00) ? ~pl : pl;
        s   = {1'b0, rec} + {1'b0, wet};
        ex  = s[10:1];
        m_mem[m_wr] = rec;
        m_wr = m_wr + 8'd1;
        m_fb = pl;
        last_exp = ex;
        @(negedge clk);
        check(mix_valid === 1'b1, {tag, " R9 valid"}, int'(mix_valid), 1);
        check(mix_out === ex, {tag, " R3 R4 R9 mix"}, int'(mix_out), int'(ex));
        smp_valid = 1'b0;
    endtask

    // Idle cycles: no pulse, output held (R9), index untouched (R3 via later strobes).
    task automatic idle_check(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(mix_valid === 1'b0, "R9 idle valid", int'(mix_valid), 0);
            check(mix_out === last_exp, "R9 idle hold", int'(mix_out), int'(last_exp));
        end
    endtask

    task automatic wait_fill(input bit drive_strobes);
        int cyc = 0;
        rst_n = 1'b1;
        while (cyc < 1000) begin
            smp_valid = drive_strobes && (cyc < 12);
            @(negedge clk);
            cyc++;
            if (cyc <= 12 && drive_strobes) begin
                check(mix_valid === 1'b0, "R2 busy strobe valid", int'(mix_valid), 0);
                check(mix_out === 10'h200, "R2 busy strobe mix", int'(mix_out), 'h200);
            end
            if (!busy) break;
        end
        smp_valid = 1'b0;
        check(cyc == 256, "R1 fill length", cyc, 256);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_in = '0; delay_off = '0; regen_mode_n = 2'b11;
        model_reset();
        repeat (3) @(negedge clk);
        check(busy === 1'b1, "R1 reset busy", int'(busy), 1);
        check(mix_valid === 1'b0, "R1 reset valid", int'(mix_valid), 0);
        check(mix_out === 10'h200, "R1 reset mix", int'(mix_out), 'h200);
        wait_fill(1'b1);

        // R1: untouched entries read as mid-scale (x=0 gives 0x100).
        strobe(10'h000, 8'd128, 2'b11, "R1 fill content");
        strobe(10'h3FF, 8'd7, 2'b11, "R1 fill content");

        // Sweep every mode; offsets include 0, 1 and 255; inputs include the rails.
        for (int md = 0; md < 4; md++) begin
            logic [1:0] mcode;
            string tg;
            case (md)
                0: begin mcode = 2'b11; tg = "R5"; end
                1: begin mcode = 2'b01; tg = "R6 R10"; end
                2: begin mcode = 2'b10; tg = "R7 R10"; end
                default: begin mcode = 2'b00; tg = "R8 R10"; end
            endcase
            for (int i = 0; i < 300; i++) begin
                logic [7:0] off;
                logic [9:0] x;
                case (i % 7)
                    0: off = 8'd0;
                    1: off = 8'd255;
                    2: off = 8'd1;
                    default: off = 8'((i * 37 + md * 11) & 255);
                endcase
                case (i % 11)
                    0: x = 10'h3FF;
                    1: x = 10'h000;
                    default: x = 10'((i * 613 + md * 97) & 1023);
                endcase
                strobe(x, off, mcode, tg);
                if (i % 40 == 39) idle_check(2);
            end
        end

        // Second reset mid-run: buffer and feedback return to mid-scale.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(busy === 1'b1, "R1 re-reset busy", int'(busy), 1);
        model_reset();
        wait_fill(1'b0);
        for (int i = 0; i < 24; i++)
            strobe(10'((i * 211) & 1023), 8'((i * 5 + 3) & 255), 2'b01, "R10 R1 after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule